// File: doc/BRIEF.md
# Serial Block-Write Configuration Slave

This block is a write-only slave on a two-wire serial bus. It sets the control registers of a clock generator. The block samples the bus clock and data lines with the system clock and detects start and stop conditions. It compares the first byte of a transaction with a device address that three strap pins select.

After the address, a master sends a command byte, a count byte and a run of data bytes. The slave stores the data bytes in its register bank in ascending order, beginning at register 0. The master may end the transfer with a stop after any complete byte. Registers that the transfer does not reach keep their values.

The bank loads fixed defaults at reset and presents its contents as parallel outputs. It also presents an effective view of control register 0, in which three control bits are forced to 0 while bit 0 of that register is set. The slave never acknowledges a read request.

Top module: `serial_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte only if it equals the strap-selected value. The slave acknowledges by pulling SDA low (`sda_pull` = 1) for the whole ninth SCL clock of the byte. The strap table for {strap_sel[2],strap_sel[1],strap_sel[0]} is 000→8'hDE, 001→8'hDC, 010→8'hDA, 011→8'hD8, 100→8'hD6, 101→8'hD4, 110→8'hD0, 111→8'hD2. Bit 0 of the address byte is the read/write flag.
- R2: The slave never acknowledges an address byte whose bit 0 is 1 (a read). It also acknowledges no later byte of that transaction.
- R3: The slave samples each byte on rising SCL edges, most significant bit first.
- R4: The slave acknowledges the command byte 8'h00. For any other command byte it gives no acknowledge, writes nothing and ignores the bus until the next start.
- R5: The slave acknowledges the count byte. The data bytes that follow go to registers 0, 1, 2 and upward in that order. A stop after any complete byte is legal, and registers the transfer has not reached keep their values.
- R6: The slave acknowledges data bytes past the count or past register NUM_REGS-1 but does not store them.
- R7: A start or stop condition anywhere returns the slave to the start of a transaction. A partly shifted byte is dropped and not stored.
- R8: At reset, register 0 loads 8'hA0 (bit7 = 1, bit6 = 0, bit5 = 1, bits 4..0 = 0) and every other register loads 8'hFF.
- R9: `ctl_eff` equals register 0 when bit 0 of register 0 is 0. When bit 0 is 1, `ctl_eff` equals register 0 with bits 6, 4 and 3 cleared.
- R10: `sda_pull` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as sampled from the pad |
| sda_in | input | 1 | Bus data line as sampled from the pad |
| strap_sel | input | 3 | Address strap pins |
| sda_pull | output | 1 | 1 = drive SDA low (acknowledge) |
| cfg_regs | output | NUM_REGS*8 | Register bank, register i at bits [8i+7:8i] |
| ctl_eff | output | 8 | Effective view of register 0 |

## Verification
The bench builds the slave with NUM_REGS = 3. With only three registers, a count byte of 5 runs past the end of the bank within a few bytes, so the discard path for writes beyond the bank is exercised. It sweeps all eight strap settings against every address byte from 8'hD0 to 8'hDF, with both read and write flags, and computes the expected acknowledge from the strap table. Further transactions cover several data patterns, stops after each byte, partial bytes that a stop or a repeated start cuts short, rejected commands and the masking in register 0.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } wr_req_t;

    localparam logic [7:0] BLOCK_CMD = 8'h00;
    localparam logic [7:0] EFF_MASK  = 8'hA7;

    function automatic logic [7:0] strap_to_addr(input logic [2:0] s);
        logic [2:0] k;
        k = (s[2] & s[1]) ? (s ^ 3'b001) : s;
        return 8'hDE - {4'b0, k, 1'b0};
    endfunction

    function automatic logic [7:0] reg_default(input int unsigned i);
        return (i == 0) ? 8'hA0 : 8'hFF;
    endfunction

    function automatic logic [7:0] effective_ctl(input logic [7:0] r);
        return r[0] ? (r & EFF_MASK) : r;
    endfunction

endpackage

// File: rtl/cfgslv_sync.sv
module cfgslv_sync
    import cfgslv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_pipe[STAGES-1];
        ev.sda      = sda_pipe[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_prev;
        ev.scl_fall = ~ev.scl & scl_prev;
        ev.start    = ev.scl & scl_prev & sda_prev & ~ev.sda;
        ev.stop     = ev.scl & scl_prev & ~sda_prev & ev.sda;
    end

endmodule

// File: rtl/cfgslv_proto.sv
module cfgslv_proto
    import cfgslv_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [2:0] strap_sel,
    output logic       sda_pull,
    output wr_req_t    wr
);
    phase_e     ph_q;
    logic [3:0] bitcnt_q;
    logic [7:0] sreg_q;
    logic [7:0] cnt_q;
    logic [7:0] idx_q;
    logic       pull_q;
    wr_req_t    wr_q;
    logic [7:0] my_addr;
    logic       store_ok;

    assign my_addr  = strap_to_addr(strap_sel);
    assign store_ok = (idx_q < cnt_q) && (int'(idx_q) < NUM_REGS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            bitcnt_q <= '0;
            sreg_q   <= '0;
            cnt_q    <= '0;
            idx_q    <= '0;
            pull_q   <= 1'b0;
            wr_q     <= '0;
        end else begin
            wr_q.en <= 1'b0;
            if (ev.start) begin
                ph_q     <= PH_ADDR;
                bitcnt_q <= '0;
                pull_q   <= 1'b0;
            end else if (ev.stop) begin
                ph_q     <= PH_IDLE;
                bitcnt_q <= '0;
                pull_q   <= 1'b0;
            end else if (ph_q != PH_IDLE && ph_q != PH_SKIP) begin
                if (ev.scl_rise && bitcnt_q < 4'd8) begin
                    sreg_q   <= {sreg_q[6:0], ev.sda};
                    bitcnt_q <= bitcnt_q + 4'd1;
                end else if (ev.scl_fall && bitcnt_q == 4'd8) begin
                    bitcnt_q <= 4'd9;
                    unique case (ph_q)
                        PH_ADDR: begin
                            if (sreg_q == my_addr) begin
                                pull_q <= 1'b1;
                                ph_q   <= PH_CMD;
                            end else begin
                                ph_q   <= PH_SKIP;
                            end
                        end
                        PH_CMD: begin
                            if (sreg_q == BLOCK_CMD) begin
                                pull_q <= 1'b1;
                                ph_q   <= PH_COUNT;
                            end else begin
                                ph_q   <= PH_SKIP;
                            end
                        end
                        PH_COUNT: begin
                            pull_q <= 1'b1;
                            cnt_q  <= sreg_q;
                            idx_q  <= '0;
                            ph_q   <= PH_DATA;
                        end
                        default: begin
                            pull_q    <= 1'b1;
                            wr_q.en   <= store_ok;
                            wr_q.idx  <= idx_q;
                            wr_q.data <= sreg_q;
                            if (idx_q != 8'hFF) idx_q <= idx_q + 8'd1;
                        end
                    endcase
                end else if (ev.scl_fall && bitcnt_q == 4'd9) begin
                    pull_q   <= 1'b0;
                    bitcnt_q <= '0;
                end
            end
        end
    end

    assign sda_pull = pull_q;
    assign wr       = wr_q;

    // R10: the acknowledge drive moves only while SCL is low
    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(pull_q) |-> !ev.scl);

    // R2: an acknowledge that follows an address byte never answers a read
    p_no_read_ack_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(pull_q) && $past(ph_q) == PH_ADDR) |-> ($past(sreg_q[0]) == 1'b0));

    // R7: a start condition clears the acknowledge and the bit position
    p_start_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (!pull_q && bitcnt_q == 4'd0 && ph_q == PH_ADDR));

    // R6: a store never goes past the bank or the received count
    p_store_bound_r6: assert property (@(posedge clk) disable iff (rst)
        wr_q.en |-> (int'(wr_q.idx) < NUM_REGS && wr_q.idx < cnt_q));

    // R4: data stores happen only in the data phase
    p_store_phase_r4: assert property (@(posedge clk) disable iff (rst)
        wr_q.en |-> (ph_q == PH_DATA));

endmodule

// File: rtl/cfgslv_regbank.sv
module cfgslv_regbank
    import cfgslv_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr,
    output logic [NUM_REGS*8-1:0] regs_flat,
    output logic [7:0]            eff0
);
    logic [7:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= reg_default(i);
            end else if (wr.en && wr.idx == 8'(i)) begin
                regs[i] <= wr.data;
            end
        end
        assign regs_flat[i*8 +: 8] = regs[i];
    end

    assign eff0 = effective_ctl(regs[0]);

    // R9: gated control bits read as zero while bit 0 is set
    p_eff_gate_r9: assert property (@(posedge clk) disable iff (rst)
        regs[0][0] |-> (eff0[6] == 1'b0 && eff0[4:3] == 2'b00));

    // R5: a register changes only on a store aimed at it
    p_reg0_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !($past(wr.en) && $past(wr.idx) == 8'd0) |-> $stable(regs[0]));

endmodule

// File: rtl/serial_cfg_slave.sv
module serial_cfg_slave
    import cfgslv_pkg::*;
#(
    parameter int NUM_REGS    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic [2:0]            strap_sel,
    output logic                  sda_pull,
    output logic [NUM_REGS*8-1:0] cfg_regs,
    output logic [7:0]            ctl_eff
);
    bus_ev_t ev;
    wr_req_t wr;

    cfgslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    cfgslv_proto #(.NUM_REGS(NUM_REGS)) u_proto (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap_sel (strap_sel),
        .sda_pull  (sda_pull),
        .wr        (wr)
    );

    cfgslv_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .regs_flat (cfg_regs),
        .eff0      (ctl_eff)
    );

endmodule

// File: tb/serial_cfg_slave_tb.sv
module serial_cfg_slave_tb;
    localparam int NR = 3;
    localparam int Q  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic [2:0]    strap = 3'b000;
    logic          pull;
    logic [NR*8-1:0] regs;
    logic [7:0]    eff;
    wire           sda_line = sda_m & ~pull;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0] exp_r [NR];

    always #10 clk = ~clk;

    serial_cfg_slave #(.NUM_REGS(NR), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .strap_sel(strap), .sda_pull(pull), .cfg_regs(regs), .ctl_eff(eff)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            summary();
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] tbl(input logic [2:0] s);
        case (s)
            3'd0: return 8'hDE; 3'd1: return 8'hDC; 3'd2: return 8'hDA; 3'd3: return 8'hD8;
            3'd4: return 8'hD6; 3'd5: return 8'hD4; 3'd6: return 8'hD0; default: return 8'hD2;
        endcase
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
        ack = ~sda_line & pull;
        w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < NR; i++) chk(tag, {24'b0, regs[i*8 +: 8]}, {24'b0, exp_r[i]});
        chk(tag, {24'b0, eff}, {24'b0, exp_r[0][0] ? (exp_r[0] & 8'hA7) : exp_r[0]});
    endtask

    // Full block write to strap 0; acks each byte; model updated per R5/R6
    task automatic block_write(input string tag, input logic [7:0] cnt,
                               input logic [7:0] d [], input logic do_stop);
        logic a;
        bus_start();
        send_byte(8'hDE, a); chk(tag, {31'b0, a}, 32'd1);
        send_byte(8'h00, a); chk(tag, {31'b0, a}, 32'd1);
        send_byte(cnt, a);   chk(tag, {31'b0, a}, 32'd1);
        foreach (d[k]) begin
            send_byte(d[k], a);
            chk(tag, {31'b0, a}, 32'd1);
            if (k < int'(cnt) && k < NR) exp_r[k] = d[k];
        end
        if (do_stop) bus_stop();
        w(4);
    endtask

    initial begin
        logic a;
        logic [7:0] d [];
        exp_r[0] = 8'hA0; exp_r[1] = 8'hFF; exp_r[2] = 8'hFF;
        w(5); rst = 1'b0; w(3);

        // R8: reset values
        check_regs("R8 reset");
        chk("R1 idle release", {31'b0, pull}, 32'd0);

        // R1 / R2: strap sweep over address bytes D0..DF
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            w(2);
            for (int ad = 8'hD0; ad <= 8'hDF; ad++) begin
                bus_start();
                send_byte(8'(ad), a);
                bus_stop();
                if (ad[0]) chk("R2 read nack", {31'b0, a}, 32'd0);
                else       chk("R1 strap match", {31'b0, a}, {31'b0, (8'(ad) == tbl(3'(s)))});
            end
        end
        strap = 3'b000;
        check_regs("R1 sweep no write");

        // R2: read request, later bytes also unanswered
        bus_start(); send_byte(8'hDF, a); chk("R2 read addr", {31'b0, a}, 32'd0);
        send_byte(8'h00, a); chk("R2 after read", {31'b0, a}, 32'd0);
        bus_stop();

        // R3 / R5: full write, MSB first
        d = '{8'h11, 8'h22, 8'h33};
        block_write("R3 R5 full", 8'd3, d, 1'b1);
        check_regs("R3 R5 full");

        // R5: stop after first data byte, others held
        d = '{8'h5A};
        block_write("R5 early stop", 8'd3, d, 1'b1);
        check_regs("R5 early stop");

        // R6: bytes beyond count acked, not stored
        d = '{8'h40, 8'h81, 8'hE7};
        block_write("R6 past count", 8'd2, d, 1'b1);
        check_regs("R6 past count");

        // R6: bytes beyond register bank acked, not stored
        d = '{8'h0C, 8'hC0, 8'h3C, 8'h99, 8'h66};
        block_write("R6 past bank", 8'd5, d, 1'b1);
        check_regs("R6 past bank");

        // R5: count 0 stores nothing
        d = '{8'h77};
        block_write("R5 count zero", 8'd0, d, 1'b1);
        check_regs("R5 count zero");

        // R4: non-block command refused
        bus_start(); send_byte(8'hDE, a); chk("R4 addr", {31'b0, a}, 32'd1);
        send_byte(8'h01, a); chk("R4 cmd 01 nack", {31'b0, a}, 32'd0);
        send_byte(8'h01, a); chk("R4 ignored count", {31'b0, a}, 32'd0);
        send_byte(8'h55, a); chk("R4 ignored data", {31'b0, a}, 32'd0);
        bus_stop(); w(4);
        check_regs("R4 no write");

        // R7: partial byte cut by stop
        d = '{8'hC3};
        block_write("R7 partial", 8'd2, d, 1'b0);
        send_bits(8'hAA, 4);
        bus_stop(); w(4);
        check_regs("R7 stop mid byte");

        // R7: partial byte cut by repeated start, then a clean transaction
        bus_start(); send_byte(8'hDE, a); send_bits(8'h00, 3);
        d = '{8'h58, 8'h12};
        block_write("R7 restart", 8'd2, d, 1'b1);
        check_regs("R7 restart");

        // R9: bit 0 set masks bits 6,4,3
        d = '{8'h59};
        block_write("R9 mask", 8'd1, d, 1'b1);
        check_regs("R9 mask");
        chk("R9 eff value", {24'b0, eff}, 32'h01);

        // R8: reset again restores defaults
        rst = 1'b1; w(2); rst = 1'b0; w(2);
        exp_r[0] = 8'hA0; exp_r[1] = 8'hFF; exp_r[2] = 8'hFF;
        check_regs("R8 second reset");

        summary();
    end

endmodule